// File: doc/BRIEF.md
# Packed-Command Field Update Engine over SPI

This block lets a host change one bit field inside a byte-wide register of a serially attached converter by writing a single 32-bit word. The word carries an opcode, a remote register address, a bit mask and a right-aligned field value. When the opcode selects the update, the engine reads the remote register over SPI. It then aligns the value to the lowest set bit of the mask and merges it into the masked bits. It writes the merged byte back, then runs a conversion transfer. The conversion result appears on a result port.

The host does no shifting, masking or bus sequencing of its own. It issues the word, waits for the busy flag to drop, and takes the result. Words that arrive while a sequence is running are discarded, and so are words with an opcode the engine does not know. Either case sets a sticky error flag that only reset clears.

Top module: `fieldcmd_engine`

## Requirements
- R1: The command word is split as opcode in bits 31:24, remote address in bits 23:16, mask in bits 15:8 and field value in bits 7:0. Opcode 0x22 (parameter) starts the update sequence.
- R2: The register read is a 16-clock frame. MOSI sends 0x80 OR the address, MSB first, and the last 8 MISO bits are the register data. The SPI is mode 0: SCLK idles low and MOSI changes only on falling edges.
- R3: The written byte equals (old AND NOT mask) OR ((value shifted left by s) AND mask), where s is the index of the lowest set bit of the mask. Shifted value bits outside the mask are lost.
- R4: The write-back is a 16-clock frame that sends the address with bit 7 cleared, then the merged byte.
- R5: The three frames run in the order read, write, conversion, each under its own chip-select assertion. The conversion frame sends the byte 0xFF (parameter) and then clocks in 16 result bits, MSB first.
- R6: Busy is high in the cycle after an accepted command word and falls in the cycle the result port takes the conversion value.
- R7: A command word written while busy is dropped without any effect on the running sequence or the SPI traffic, and it sets the error flag.
- R8: A word with any other opcode starts no SPI frame, leaves busy low and sets the error flag.
- R9: The error flag stays set until reset.
- R10: A mask of zero still performs the read and the write-back, and the remote register keeps its old value.
- R11: After reset, chip select is high, SCLK is low, busy and error are low and the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle write strobe for the command word |
| cmd_word | input | 32 | Packed command: opcode, address, mask, value |
| busy | output | 1 | Sequence running; low means result is current |
| err | output | 1 | Sticky flag for dropped or unknown commands |
| result | output | 16 | Last conversion value |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the converter |
| spi_miso | input | 1 | SPI data from the converter |

## Verification
A wrong sequencer state shows up at the SPI pins within one frame. It appears as a missing or extra chip-select pulse, a frame of the wrong length, or a read or write code on the wrong byte. A faulty merge or shift is visible at the end of the write frame as a wrong byte stored in the modelled remote register. The bench compares that byte with an arithmetic prediction for every mask value. A corrupted busy or error state shows at the ports in the cycle after the command strobe.

// File: rtl/fce_pkg.sv
package fce_pkg;

  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] op;
    logic [BYTE_W-1:0] addr;
    logic [BYTE_W-1:0] mask;
    logic [BYTE_W-1:0] val;
  } fce_cmd_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2,
    SEQ_CONV  = 2'd3
  } fce_seq_e;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_RUN  = 2'd1,
    SH_GAP  = 2'd2
  } fce_sh_e;

endpackage

// File: rtl/fce_field_merge.sv
module fce_field_merge
  import fce_pkg::*;
(
  input  logic [BYTE_W-1:0] old_byte,
  input  logic [BYTE_W-1:0] mask,
  input  logic [BYTE_W-1:0] value,
  output logic [BYTE_W-1:0] new_byte
);

  localparam int SH_W = $clog2(BYTE_W);

  logic [SH_W-1:0]   lsb_idx;
  logic [BYTE_W-1:0] aligned;

  // index of the lowest set mask bit; zero when the mask is empty
  always_comb begin
    lsb_idx = '0;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      if (mask[i]) lsb_idx = SH_W'(i);
    end
  end

  assign aligned  = value << lsb_idx;
  assign new_byte = (old_byte & ~mask) | (aligned & mask);

endmodule

// File: rtl/fce_spi_shifter.sv
module fce_spi_shifter
  import fce_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int FRAME_W = 24,
  localparam int NB_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic [NB_W-1:0]    nbits,
  output logic               done,
  output logic [FRAME_W-1:0] rx_word,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);

  localparam int DW = $clog2(CLK_DIV) + 1;

  fce_sh_e            st_q, st_d;
  logic [DW-1:0]      div_q, div_d;
  logic [NB_W-1:0]    bit_q, bit_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [FRAME_W-1:0] rx_q, rx_d;
  logic               sclk_q, sclk_d;
  logic               cs_q, cs_d;
  logic               done_q, done_d;
  logic               tick;

  assign tick = (div_q == DW'(CLK_DIV - 1));

  always_comb begin
    st_d   = st_q;
    div_d  = div_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    sclk_d = sclk_q;
    cs_d   = cs_q;
    done_d = 1'b0;
    unique case (st_q)
      SH_IDLE: begin
        if (start) begin
          st_d   = SH_RUN;
          tx_d   = tx_word;
          rx_d   = '0;
          bit_d  = nbits;
          div_d  = '0;
          sclk_d = 1'b0;
          cs_d   = 1'b0;
        end
      end
      SH_RUN: begin
        div_d = tick ? '0 : div_q + 1'b1;
        if (tick) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
            rx_d   = {rx_q[FRAME_W-2:0], miso};
          end else begin
            sclk_d = 1'b0;
            tx_d   = tx_q << 1;
            bit_d  = bit_q - 1'b1;
            if (bit_q == NB_W'(1)) begin
              cs_d = 1'b1;
              st_d = SH_GAP;
            end
          end
        end
      end
      SH_GAP: begin
        div_d = tick ? '0 : div_q + 1'b1;
        if (tick) begin
          st_d   = SH_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
      done_q <= done_d;
    end
  end

  assign done    = done_q;
  assign rx_word = rx_q;
  assign sclk    = sclk_q;
  assign cs_n    = cs_q;
  assign mosi    = tx_q[FRAME_W-1];

endmodule

// File: rtl/fieldcmd_engine.sv
module fieldcmd_engine
  import fce_pkg::*;
#(
  parameter int          CLK_DIV  = 4,
  parameter int          RES_W    = 16,
  parameter logic [7:0]  OPC_RMW  = 8'h22,
  parameter logic [7:0]  CONV_CMD = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [31:0]      cmd_word,
  output logic             busy,
  output logic             err,
  output logic [RES_W-1:0] result,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);

  localparam int FRAME_W = BYTE_W + RES_W;
  localparam int REG_W   = 2 * BYTE_W;
  localparam int NB_W    = $clog2(FRAME_W + 1);

  fce_seq_e           st_q, st_d;
  fce_cmd_t           cmd_q, cmd_d, cmd_in;
  logic               err_q, err_d;
  logic [RES_W-1:0]   res_q, res_d;
  logic               start_q, start_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [NB_W-1:0]    nb_q, nb_d;
  logic               sh_done;
  logic [FRAME_W-1:0] sh_rx;
  logic [BYTE_W-1:0]  merged;

  assign cmd_in = cmd_word;

  fce_field_merge u_merge (
    .old_byte (sh_rx[BYTE_W-1:0]),
    .mask     (cmd_q.mask),
    .value    (cmd_q.val),
    .new_byte (merged)
  );

  fce_spi_shifter #(
    .CLK_DIV (CLK_DIV),
    .FRAME_W (FRAME_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_q),
    .tx_word (tx_q),
    .nbits   (nb_q),
    .done    (sh_done),
    .rx_word (sh_rx),
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .miso    (spi_miso)
  );

  always_comb begin
    st_d    = st_q;
    cmd_d   = cmd_q;
    err_d   = err_q;
    res_d   = res_q;
    start_d = 1'b0;
    tx_d    = tx_q;
    nb_d    = nb_q;
    if (cmd_valid && (st_q != SEQ_IDLE)) err_d = 1'b1;
    unique case (st_q)
      SEQ_IDLE: begin
        if (cmd_valid) begin
          if (cmd_in.op == OPC_RMW) begin
            cmd_d   = cmd_in;
            st_d    = SEQ_READ;
            start_d = 1'b1;
            tx_d    = {8'h80 | cmd_in.addr, {(FRAME_W-BYTE_W){1'b0}}};
            nb_d    = NB_W'(REG_W);
          end else begin
            err_d = 1'b1;
          end
        end
      end
      SEQ_READ: begin
        if (sh_done) begin
          st_d    = SEQ_WRITE;
          start_d = 1'b1;
          tx_d    = {1'b0, cmd_q.addr[BYTE_W-2:0], merged, {(FRAME_W-REG_W){1'b0}}};
          nb_d    = NB_W'(REG_W);
        end
      end
      SEQ_WRITE: begin
        if (sh_done) begin
          st_d    = SEQ_CONV;
          start_d = 1'b1;
          tx_d    = {CONV_CMD, {RES_W{1'b0}}};
          nb_d    = NB_W'(FRAME_W);
        end
      end
      SEQ_CONV: begin
        if (sh_done) begin
          res_d = sh_rx[RES_W-1:0];
          st_d  = SEQ_IDLE;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      cmd_q   <= '0;
      err_q   <= 1'b0;
      res_q   <= '0;
      start_q <= 1'b0;
      tx_q    <= '0;
      nb_q    <= '0;
    end else begin
      st_q    <= st_d;
      cmd_q   <= cmd_d;
      err_q   <= err_d;
      res_q   <= res_d;
      start_q <= start_d;
      tx_q    <= tx_d;
      nb_q    <= nb_d;
    end
  end

  assign busy   = (st_q != SEQ_IDLE);
  assign err    = err_q;
  assign result = res_q;

endmodule

// File: rtl/fieldcmd_engine_chk.sv
module fieldcmd_engine_chk #(
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             busy,
  input logic             err,
  input logic [RES_W-1:0] result,
  input logic             spi_sclk,
  input logic             spi_cs_n,
  input logic             spi_mosi
);

  // R2: mode 0 clock idles low whenever the slave is deselected
  a_r2_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R2: MOSI holds while SCLK stays high
  a_r2_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  // R6: a sequence only starts from a command strobe
  a_r6_busy_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  // R7: strobe during a sequence raises the error flag
  a_r7_drop_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> err);

  // R9: error flag never falls outside reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R8: no SPI frame while idle
  a_r8_no_spi_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);

  // R6: result only moves when a sequence ends
  a_r6_result_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(result));

endmodule

bind fieldcmd_engine fieldcmd_engine_chk #(.RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .err       (err),
  .result    (result),
  .spi_sclk  (spi_sclk),
  .spi_cs_n  (spi_cs_n),
  .spi_mosi  (spi_mosi)
);

// File: tb/fieldcmd_engine_tb.sv
module fieldcmd_engine_tb;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [31:0] cmd_word;
  logic        busy;
  logic        err;
  logic [15:0] result;
  logic        spi_sclk;
  logic        spi_cs_n;
  logic        spi_mosi;
  logic        spi_miso;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;

  fieldcmd_engine #(.CLK_DIV(1)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .busy      (busy),
    .err       (err),
    .result    (result),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n),
    .spi_mosi  (spi_mosi),
    .spi_miso  (spi_miso)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- remote converter model ----------------
  logic [7:0]  regs [128];
  logic [15:0] conv_val;
  int          bitn;
  logic [7:0]  b0, b1;
  logic [23:0] resp;
  logic        in_frame = 1'b0;
  int          frames = 0;
  int          bad_frames = 0;
  logic [5:0]  seq_log = '0;

  always @(negedge spi_cs_n) begin
    in_frame = 1'b1;
    bitn = 0; b0 = 0; b1 = 0; resp = 0;
    spi_miso = 1'b0;
    frames++;
  end

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (bitn < 8) b0 = {b0[6:0], spi_mosi};
      else if (bitn < 16) b1 = {b1[6:0], spi_mosi};
      bitn++;
      if (bitn == 8) begin
        if (b0 == 8'hFF) resp = {8'h00, conv_val};
        else if (b0[7]) resp = {8'h00, regs[b0[6:0]], 8'h00};
      end
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n && bitn < 24) spi_miso = resp[23-bitn];
  end

  always @(posedge spi_cs_n) begin
    if (in_frame) begin
      in_frame = 1'b0;
      if (b0 == 8'hFF && bitn == 24) begin
        seq_log = {seq_log[3:0], 2'b11};
        conv_val = conv_val + 16'h1357;
      end else if (b0[7] && bitn == 16) begin
        seq_log = {seq_log[3:0], 2'b01};
      end else if (!b0[7] && bitn == 16) begin
        regs[b0[6:0]] = b1;
        seq_log = {seq_log[3:0], 2'b10};
      end else begin
        bad_frames++;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  task automatic apply_reset();
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic strobe(input logic [31:0] w);
    @(negedge clk);
    cmd_word  = w;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
  endtask

  function automatic logic [7:0] predict(input logic [7:0] old, input logic [7:0] m,
                                         input logic [7:0] v);
    int lsb;
    int prod;
    lsb  = int'(m) & ((~int'(m) + 1) & 8'hFF);
    prod = int'(v) * lsb;
    return (old & ~m) | (prod[7:0] & m);
  endfunction

  task automatic run_cmd(input logic [7:0] a, input logic [7:0] m, input logic [7:0] v,
                         input string tag);
    logic [7:0]  old, expb;
    logic [15:0] expr;
    int          f0;
    old  = regs[a[6:0]];
    expb = predict(old, m, v);
    expr = conv_val;
    f0   = frames;
    strobe({8'h22, a, m, v});
    check(busy === 1'b1, {tag, " R6 busy after strobe"}, busy, 1);
    wait_idle();
    check(regs[a[6:0]] === expb, {tag, " R3 R4 merged byte"}, regs[a[6:0]], expb);
    check(result === expr, {tag, " R5 result"}, result, expr);
    check(seq_log === 6'b011011 && frames == f0 + 3, {tag, " R1 R2 R5 frame order"},
          seq_log, 6'b011011);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    spi_miso = 1'b0;
    conv_val = 16'hA5C3;
    for (int i = 0; i < 128; i++) regs[i] = 8'((i * 29 + 7) ^ (i << 3));
    apply_reset();
    // R11 reset state
    check(spi_cs_n === 1'b1, "R11 cs_n", spi_cs_n, 1);
    check(spi_sclk === 1'b0, "R11 sclk", spi_sclk, 0);
    check(busy === 1'b0, "R11 busy", busy, 0);
    check(err === 1'b0, "R11 err", err, 0);
    check(result === 16'h0, "R11 result", result, 0);

    // R3 sweep: every mask, two values each
    for (int m = 0; m < 256; m++) begin
      for (int k = 0; k < 2; k++) begin
        run_cmd(8'((m * 7 + k * 53) % 127), 8'(m), 8'(m * 13 + k * 91 + 5), "sweep");
      end
    end
    check(bad_frames == 0, "R2 R4 frame lengths", bad_frames, 0);
    check(err === 1'b0, "R9 no error after legal commands", err, 0);

    // R10 zero mask: read and write still happen, byte unchanged
    begin
      logic [7:0] old;
      old = regs[42];
      run_cmd(8'd42, 8'h00, 8'hFF, "R10 zero mask");
      check(regs[42] === old, "R10 byte unchanged", regs[42], old);
    end

    // R7 command while busy is dropped
    begin
      logic [7:0] old9, exp5;
      int f0;
      old9 = regs[9];
      exp5 = predict(regs[5], 8'h38, 8'h02);
      f0 = frames;
      strobe({8'h22, 8'd5, 8'h38, 8'h02});
      repeat (4) @(negedge clk);
      strobe({8'h22, 8'd9, 8'hFF, 8'hAA});
      wait_idle();
      repeat (10) @(negedge clk);
      check(err === 1'b1, "R7 err set", err, 1);
      check(regs[9] === old9, "R7 dropped target untouched", regs[9], old9);
      check(regs[5] === exp5, "R7 running command completes", regs[5], exp5);
      check(frames == f0 + 3, "R7 frame count", frames, f0 + 3);
      repeat (30) @(negedge clk);
      check(err === 1'b1, "R9 err sticky", err, 1);
    end

    // R8 unknown opcode after a fresh reset
    apply_reset();
    check(err === 1'b0, "R9 err cleared by reset", err, 0);
    begin
      int f0;
      logic seen_busy;
      logic [7:0] old;
      old = regs[17];
      f0 = frames;
      seen_busy = 1'b0;
      strobe({8'h5A, 8'd17, 8'hFF, 8'h00});
      for (int n = 0; n < 40; n++) begin
        if (busy) seen_busy = 1'b1;
        @(negedge clk);
      end
      check(seen_busy == 1'b0, "R8 busy stays low", seen_busy, 0);
      check(frames == f0, "R8 no SPI frames", frames, f0);
      check(err === 1'b1, "R8 err set", err, 1);
      check(regs[17] === old, "R8 register untouched", regs[17], old);
    end

    // R1 field split and worked example: mask 0x38 value 2 lands in bits 5..3
    regs[20] = 8'hFF;
    run_cmd(8'd20, 8'h38, 8'h02, "R1 example");
    check(regs[20] === 8'hD7, "R1 example byte", regs[20], 8'hD7);

    finish_run();
  end

endmodule